// File: doc/BRIEF.md
# Synthesizer Divider Configuration Register

This block holds the settings that steer a clock synthesizer's dividers: a 9-bit feedback modulus, a 2-bit output divider code and a 3-bit test field. It drives them from output latches. Software or board logic can fill those latches in two ways. The first is a level-sensitive parallel path from dedicated pins, which covers the modulus and the output code only. The second is a 14-bit serial shift chain with its own data and shift-clock inputs and a separate capture strobe.

All controls are sampled in the block's clock domain. The serial clock and the capture strobe act on their rising edges, and those edges are found by comparing each input with its value one cycle earlier. Next to the raw output code the block gives the decoded power-of-two ratio. It also raises a registered flag whenever the latched modulus lies outside the band in which the loop can lock.

Top module: `synth_cfg_reg`

## Requirements
- R1: After reset, the modulus output is 200, the code output is 00, the ratio output is 1, the test output is 000 and the range flag is low.
- R2: A bit on `ser_din` enters the chain at each clock edge where `ser_clk` is high and was low one edge before. The chain is loaded in this order: the test field first, then the code MSB first, then the modulus MSB first. After 14 shifts, the last bit shifted in is modulus bit 0.
- R3: The edge at which `ser_latch` is first seen high copies the chain into the modulus, code and test latches, and the outputs show the new values after that edge. While `ser_latch` stays high, the latches do not capture again.
- R4: At each edge where `par_follow` is high and no capture strobe edge occurs, the modulus and code latches take `m_par` and `n_par`. The test latch is left unchanged.
- R5: If a capture strobe edge and `par_follow` fall on the same clock edge, the latches take the chain contents.
- R6: The ratio output is 1 for code 00, 2 for code 10, 4 for code 01 and 8 for code 11.
- R7: The range flag is high exactly when the latched modulus is below 200 or above 400.
- R8: Shifting the chain without a capture strobe edge leaves all outputs unchanged.
- R9: A serial load of modulus 262 with code 01 gives a modulus output of 100000110 and a code output of 01 (divide-by-4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all controls are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial configuration data |
| ser_clk | input | 1 | Serial shift clock; acts on its rising edge |
| ser_latch | input | 1 | Capture strobe for the chain; acts on its rising edge |
| par_follow | input | 1 | Level control; when high, the latches follow the parallel pins |
| m_par | input | 9 | Parallel modulus value |
| n_par | input | 2 | Parallel output divider code |
| m_out | output | 9 | Latched feedback modulus |
| n_out | output | 2 | Latched output divider code |
| ratio_out | output | 4 | Decoded output division ratio (1, 2, 4 or 8) |
| test_out | output | 3 | Latched test field |
| m_range_err | output | 1 | High when the latched modulus is outside 200..400 |

## Verification
The checker assumes that `ser_clk`, `ser_latch` and `par_follow` are synchronous to `clk` and stay steady for at least one full clock period, so that each edge of them is seen on exactly one sampling edge. The bench changes every input only on the falling clock edge, and it holds each serial-clock level for a whole period. The checker also treats a raised `ser_latch` as one that may stay high for any time. The bench therefore includes a run where the strobe is held high while new bits are shifted in, and a run where the strobe and the parallel control are active together.

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg #(
  parameter int MW    = 9,
  parameter int NW    = 2,
  parameter int TW    = 3,
  parameter int M_MIN = 200,
  parameter int M_MAX = 400,
  parameter int M_RST = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              ser_clk,
  input  logic              ser_latch,
  input  logic              par_follow,
  input  logic [MW-1:0]     m_par,
  input  logic [NW-1:0]     n_par,
  output logic [MW-1:0]     m_out,
  output logic [NW-1:0]     n_out,
  output logic [(1<<NW)-1:0] ratio_out,
  output logic [TW-1:0]     test_out,
  output logic              m_range_err
);
  localparam int SRW = MW + NW + TW;
  localparam int RW  = 1 << NW;

  logic [SRW-1:0] chain;
  logic           sclk_q, slat_q;
  logic           shift_en, cap_en;
  logic [MW-1:0]  m_nxt;
  logic [NW-1:0]  n_nxt;
  logic [TW-1:0]  t_nxt;
  logic [NW-1:0]  n_exp;

  assign shift_en = ser_clk & ~sclk_q;
  assign cap_en   = ser_latch & ~slat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      slat_q <= 1'b0;
      chain  <= '0;
    end else begin
      sclk_q <= ser_clk;
      slat_q <= ser_latch;
      if (shift_en) chain <= {chain[SRW-2:0], ser_din};
    end
  end

  always_comb begin
    m_nxt = m_out;
    n_nxt = n_out;
    t_nxt = test_out;
    if (cap_en) begin
      m_nxt = chain[MW-1:0];
      n_nxt = chain[MW+NW-1:MW];
      t_nxt = chain[SRW-1:MW+NW];
    end else if (par_follow) begin
      m_nxt = m_par;
      n_nxt = n_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out       <= MW'(M_RST);
      n_out       <= '0;
      test_out    <= '0;
      m_range_err <= (M_RST < M_MIN) || (M_RST > M_MAX);
    end else begin
      m_out       <= m_nxt;
      n_out       <= n_nxt;
      test_out    <= t_nxt;
      m_range_err <= (int'(m_nxt) < M_MIN) || (int'(m_nxt) > M_MAX);
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_rev
    assign n_exp[i] = n_out[NW-1-i];
  end

  assign ratio_out = RW'(1) << n_exp;
endmodule

module synth_cfg_reg_chk #(
  parameter int MW    = 9,
  parameter int NW    = 2,
  parameter int TW    = 3,
  parameter int M_MIN = 200,
  parameter int M_MAX = 400
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ser_latch,
  input logic                par_follow,
  input logic [MW-1:0]       m_par,
  input logic [NW-1:0]       n_par,
  input logic [MW-1:0]       m_out,
  input logic [NW-1:0]       n_out,
  input logic [(1<<NW)-1:0]  ratio_out,
  input logic [TW-1:0]       test_out,
  input logic                m_range_err
);
  logic lat_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_prev <= 1'b0;
    else        lat_prev <= ser_latch;

  a_r6_ratio_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ratio_out) == 1);

  a_r7_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    m_range_err == ((int'(m_out) < M_MIN) || (int'(m_out) > M_MAX)));

  a_r4_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (par_follow && !ser_latch) |=> (m_out == $past(m_par)) && (n_out == $past(n_par)));

  a_r4_test_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_latch |=> $stable(test_out));

  a_r3_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_latch && lat_prev && !par_follow) |=> $stable(m_out) && $stable(n_out) && $stable(test_out));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_latch && !par_follow) |=> $stable(m_out) && $stable(n_out));
endmodule

bind synth_cfg_reg synth_cfg_reg_chk #(
  .MW(MW), .NW(NW), .TW(TW), .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_latch(ser_latch), .par_follow(par_follow),
  .m_par(m_par), .n_par(n_par), .m_out(m_out), .n_out(n_out),
  .ratio_out(ratio_out), .test_out(test_out), .m_range_err(m_range_err)
);

// File: tb/test_synth_cfg_reg.sv
`timescale 1ns/1ps
module test_synth_cfg_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_din = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0, par_follow = 1'b0;
  logic [8:0] m_par = '0;
  logic [1:0] n_par = '0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [3:0] ratio_out;
  logic [2:0] test_out;
  logic       m_range_err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  synth_cfg_reg i_synth_cfg_reg (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .par_follow(par_follow), .m_par(m_par), .n_par(n_par),
    .m_out(m_out), .n_out(n_out), .ratio_out(ratio_out), .test_out(test_out),
    .m_range_err(m_range_err)
  );

  // {test, n, m}
  localparam logic [13:0] VEC [7] = '{
    {3'b000, 2'b01, 9'd262},
    {3'b101, 2'b00, 9'd200},
    {3'b010, 2'b11, 9'd400},
    {3'b111, 2'b10, 9'd199},
    {3'b000, 2'b00, 9'd401},
    {3'b110, 2'b11, 9'd511},
    {3'b001, 2'b10, 9'd0}
  };

  function automatic logic [3:0] exp_ratio(input logic [1:0] n);
    case (n)
      2'b00: return 4'd1;
      2'b10: return 4'd2;
      2'b01: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic exp_err(input logic [8:0] m);
    return (m < 9'd200) || (m > 9'd400);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [13:0] v);
    chk(req, m_out, v[8:0]);
    chk(req, n_out, v[10:9]);
    chk(req, test_out, v[13:11]);
    chk(req, ratio_out, exp_ratio(v[10:9]));
    chk(req, m_range_err, exp_err(v[8:0]));
  endtask

  task automatic shift_word(input logic [13:0] v);
    for (int b = 13; b >= 0; b--) begin
      ser_din = v[b];
      ser_clk = 1'b1;
      @(negedge clk);
      ser_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic strobe();
    ser_latch = 1'b1;
    @(negedge clk);
    ser_latch = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1", {3'b000, 2'b00, 9'd200});
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", {3'b000, 2'b00, 9'd200});

    // R2 R6 R7 R9 table of serial loads
    for (int i = 0; i < 7; i++) begin
      shift_word(VEC[i]);
      strobe();
      check_all(i == 0 ? "R9" : "R2", VEC[i]);
    end

    // R8 shifting without strobe leaves outputs alone
    shift_word({3'b011, 2'b10, 9'd300});
    check_all("R8", VEC[6]);

    // R4 parallel follow; test field kept
    m_par = 9'd350; n_par = 2'b11; par_follow = 1'b1;
    @(negedge clk);
    check_all("R4", {VEC[6][13:11], 2'b11, 9'd350});
    m_par = 9'd150; n_par = 2'b01;
    @(negedge clk);
    check_all("R4", {VEC[6][13:11], 2'b01, 9'd150});
    par_follow = 1'b0;
    m_par = 9'd222;
    @(negedge clk);
    chk("R4", m_out, 150);

    // R5 strobe edge wins over parallel follow
    shift_word({3'b100, 2'b10, 9'd333});
    m_par = 9'd250; n_par = 2'b00; par_follow = 1'b1; ser_latch = 1'b1;
    @(negedge clk);
    check_all("R5", {3'b100, 2'b10, 9'd333});
    par_follow = 1'b0; ser_latch = 1'b0;
    @(negedge clk);

    // R3 held strobe does not recapture
    shift_word({3'b010, 2'b01, 9'd210});
    ser_latch = 1'b1;
    @(negedge clk);
    check_all("R3", {3'b010, 2'b01, 9'd210});
    shift_word({3'b001, 2'b11, 9'd390});
    check_all("R3", {3'b010, 2'b01, 9'd210});
    ser_latch = 1'b0;
    @(negedge clk);
    strobe();
    check_all("R3", {3'b001, 2'b11, 9'd390});

    // R1 reset mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1", {3'b000, 2'b00, 9'd200});
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule